// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column access request into the column sequence a synchronous DRAM walks through during a burst. A start pulse carries the first column together with the burst-length code and the ordering bit taken from the mode settings. From the next clock the block presents one column per cycle. A fixed-length burst of 1, 2, 4 or 8 beats stays inside the aligned block that holds the starting column. A full-page burst walks the whole row and keeps going until it is stopped.

Two orderings are offered. Sequential order counts the low bits upward from the start and wraps inside the aligned block. Interleaved order XORs the start offset with the beat number. Interleaved order does not apply to a full page, so a full-page burst always runs in sequential order. A suspend input freezes the generator completely, and a terminate input ends the burst on the current beat. The command sequencer drives this block and takes its column and last-beat outputs.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is high and in the first cycle after it, valid_o and last_o are 0 and col_o is 0.
- R2: A start_i accepted while hold_i is low makes valid_o 1 and col_o equal to the sampled start_col_i in the following cycle.
- R3: With burst_type_i = 0 (sequential), beat i of a fixed burst of length BL shows column (start with its low log2(BL) bits replaced by (start + i) mod BL). The length codes are 0 = 1, 1 = 2, 2 = 4, 3 = 8 and 7 = full page.
- R4: With burst_type_i = 1 (interleaved) and a fixed length, beat i shows the start column with its low log2(BL) bits XORed with i.
- R5: A fixed-length burst presents exactly BL valid beats when it is neither suspended nor stopped. last_o is 1 only on the final beat, and valid_o falls in the cycle after it.
- R6: A full-page burst (code 7) steps sequentially through all 2^COL_W columns of the row, wrapping from the top column to column 0. It never raises last_o by itself. An interleaved request with code 7 also runs in sequential order.
- R7: stop_i high in a valid cycle with hold_i low drives last_o to 1 in that same cycle, and valid_o is 0 in the next cycle unless a new start is accepted.
- R8: While hold_i is high, col_o, valid_o and the beat position keep their values at the next edge, and start_i and stop_i are ignored. last_o does not react to stop_i in that cycle.
- R9: A start_i accepted during an active burst abandons that burst and begins the new one in the following cycle.
- R10: The reserved length codes 4, 5 and 6 behave as a burst length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a burst at start_col_i |
| start_col_i | input | COL_W | First column of the burst |
| burst_len_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page, others:1) |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| hold_i | input | 1 | Suspend: freezes all state and ignores commands |
| stop_i | input | 1 | Terminates the burst on the current beat |
| col_o | output | COL_W | Column of the current beat (registered) |
| valid_o | output | 1 | A burst beat is being presented (registered) |
| last_o | output | 1 | Current beat is the final one |

## Verification
The first column of a burst is due one edge after the start is accepted, and each later column one edge after the previous beat when no suspend is present. A suspended edge leaves all outputs unchanged. last_o depends on stop_i in the same cycle, so it is due in the cycle the terminate is driven, and valid_o drops one edge later. The bench applies inputs just after a falling edge. It compares the registered outputs and the same-cycle last_o a moment later against a reference model, and then advances that model by exactly one edge.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam logic [2:0] BLEN_ONE   = 3'd0;
  localparam logic [2:0] BLEN_TWO   = 3'd1;
  localparam logic [2:0] BLEN_FOUR  = 3'd2;
  localparam logic [2:0] BLEN_EIGHT = 3'd3;
  localparam logic [2:0] BLEN_PAGE  = 3'd7;

  // number of low column bits that take part in a fixed burst
  function automatic logic [1:0] fixed_log2(input logic [2:0] code);
    case (code)
      BLEN_TWO:   fixed_log2 = 2'd1;
      BLEN_FOUR:  fixed_log2 = 2'd2;
      BLEN_EIGHT: fixed_log2 = 2'd3;
      default:    fixed_log2 = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  import colgen_pkg::*;

  logic [1:0] span;
  assign span   = fixed_log2(code_i);
  assign full_o = (code_i == BLEN_PAGE);

  // bit b of the column moves within the burst when it lies below the span
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full_o | (int'(span) > b);
  end
endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign seq_col = base_i + beat_i;
  assign ilv_col = base_i ^ beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (xor_i ? ilv_col[b] : seq_col[b]) : base_i[b];
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             load_single_i,
  input  logic             adv_i,
  input  logic [COL_W-1:0] final_beat_i,
  input  logic             full_i,
  output logic [COL_W-1:0] beat_nxt_o,
  output logic             last_o
);
  logic [COL_W-1:0] beat_q;

  assign beat_nxt_o = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      last_o <= 1'b0;
    end else if (load_i) begin
      beat_q <= '0;
      last_o <= load_single_i;
    end else if (adv_i) begin
      beat_q <= beat_nxt_o;
      last_o <= !full_i && (beat_nxt_o == final_beat_i);
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       burst_len_i,
  input  logic             burst_type_i,
  input  logic             hold_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             xor_q;
  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] col_nxt;
  logic             last_q;
  logic             take;
  logic             load;
  logic             adv;
  logic             finish;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (burst_len_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  assign take   = !hold_i;
  assign last_o = valid_o && (last_q || (stop_i && take));
  assign load   = take && start_i;
  assign adv    = take && valid_o && !last_o && !start_i;
  assign finish = take && last_o && !start_i;

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk           (clk),
    .rst           (rst),
    .load_i        (load),
    .load_single_i (!dec_full && (dec_mask == '0)),
    .adv_i         (adv),
    .final_beat_i  (mask_q),
    .full_i        (full_q),
    .beat_nxt_o    (beat_nxt),
    .last_o        (last_q)
  );

  colgen_order #(.COL_W(COL_W)) u_ord (
    .base_i (base_q),
    .beat_i (beat_nxt),
    .mask_i (mask_q),
    .xor_i  (xor_q),
    .col_o  (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      xor_q   <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
    end else if (load) begin
      base_q  <= start_col_i;
      mask_q  <= dec_mask;
      full_q  <= dec_full;
      xor_q   <= burst_type_i && !dec_full;
      col_o   <= start_col_i;
      valid_o <= 1'b1;
    end else if (adv) begin
      col_o   <= col_nxt;
    end else if (finish) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             hold_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  // R1: idle right after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !last_o && col_o == '0));

  // R2: first beat follows an accepted start
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !hold_i) |=> (valid_o && col_o == $past(start_col_i)));

  // R5: last beat only inside a burst
  assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R5: a non-final beat is followed by another beat
  assert_keeps_going_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !hold_i) |=> valid_o);

  // R7: terminate ends the burst
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && stop_i && !hold_i && !start_i) |=> !valid_o);

  // R8: suspend freezes the outputs
  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> ($stable(col_o) && $stable(valid_o)));
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  localparam int COL_W = 8;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       burst_len_i = '0;
  logic             burst_type_i = 1'b0;
  logic             hold_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state (value after the most recent edge)
  bit               m_valid = 1'b0;
  int               m_beat  = 0;
  logic [COL_W-1:0] m_start = '0;
  logic [2:0]       m_code  = '0;
  logic             m_type  = 1'b0;
  string            m_vtag  = "R1";

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .burst_len_i(burst_len_i), .burst_type_i(burst_type_i),
    .hold_i(hold_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] st,
      input logic [2:0] code, input logic typ, input int beat);
    int n    = blen(code);
    int size = (n == 0) ? NCOL : n;
    int off  = int'(st) % size;
    int base = int'(st) - off;
    int o    = (typ && n != 0) ? (off ^ (beat % size)) : ((off + beat) % size);
    return COL_W'(base + o);
  endfunction

  function automatic string col_tag(input logic [2:0] code, input logic typ);
    if (code inside {3'd4, 3'd5, 3'd6}) return "R10";
    if (code == 3'd7) return "R6";
    return typ ? "R4" : "R3";
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one cycle, compare, advance the model across the next edge
  task automatic step(input logic s, input logic [COL_W-1:0] c, input logic [2:0] code,
                      input logic typ, input logic h, input logic p);
    bit e_last;
    @(negedge clk);
    start_i = s; start_col_i = c; burst_len_i = code; burst_type_i = typ;
    hold_i = h; stop_i = p;
    #1;
    e_last = m_valid && ((blen(m_code) != 0 && m_beat == blen(m_code) - 1) || (p && !h));
    chk(m_vtag, valid_o, m_valid);
    if (m_valid) chk(col_tag(m_code, m_type), col_o, exp_col(m_start, m_code, m_type, m_beat));
    chk((p && !h && m_valid) ? "R7" : (h ? "R8" : (m_code == 3'd7 ? "R6" : "R5")),
        last_o, e_last);
    if (h) begin
      m_vtag = "R8";
    end else if (s) begin
      m_vtag  = m_valid ? "R9" : "R2";
      m_valid = 1'b1; m_beat = 0; m_start = c; m_code = code; m_type = typ;
    end else if (m_valid && e_last) begin
      m_vtag  = p ? "R7" : "R5";
      m_valid = 1'b0;
    end else if (m_valid) begin
      m_vtag = "R5";
      m_beat = (m_beat + 1) % NCOL;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c01));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", valid_o, 0); chk("R1", last_o, 0); chk("R1", col_o, 0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", valid_o, 0); chk("R1", col_o, 0);

    // directed: interleaved 8 from 5, sequential 4 from 0x3e
    step(1'b1, 8'h45, 3'd3, 1'b1, 1'b0, 1'b0); idle(9);
    step(1'b1, 8'h3e, 3'd2, 1'b0, 1'b0, 1'b0); idle(5);
    // reserved length code gives one beat
    step(1'b1, 8'h91, 3'd5, 1'b0, 1'b0, 1'b0); idle(2);
    // full page interleaved request: sequential wrap over whole row, then stop
    step(1'b1, 8'hf0, 3'd7, 1'b1, 1'b0, 1'b0);
    idle(NCOL + 20);
    step(1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1);   // stop while held is ignored
    step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1);   // stop takes effect
    idle(2);
    // suspend mid burst, restart mid burst
    step(1'b1, 8'h22, 3'd3, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h77, 3'd1, 1'b0, 1'b1, 1'b0);
    idle(2);
    step(1'b1, 8'h0b, 3'd2, 1'b1, 1'b0, 1'b0);
    idle(5);

    // random mix
    for (int k = 0; k < 6000; k++) begin
      logic [2:0] code;
      int r = $urandom_range(0, 9);
      code = (r < 2) ? 3'd0 : (r < 4) ? 3'd1 : (r < 6) ? 3'd2 : (r < 8) ? 3'd3 :
             (r == 8) ? 3'd7 : 3'($urandom_range(4, 6));
      step(($urandom_range(0, 99) < (m_valid ? 3 : 30)),
           COL_W'($urandom), code, 1'($urandom),
           ($urandom_range(0, 99) < 15),
           ($urandom_range(0, 99) < (m_code == 3'd7 ? 4 : 3)));
    end
    idle(4);
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule